// File: doc/BRIEF.md
# Dual-Mode Host Bus Register Port

This block is the host-side access port of a switching device. A host processor reaches a small set of configuration registers and two per-channel memories (a connection memory and a data memory) through one parallel bus. A strap input picks the bus style. With the strap low the bus is non-multiplexed: a separate 8-bit address and a 16-bit data path. With the strap high the low data byte also carries the address, which is captured on the rising edge of an address-latch strobe. The level of the combined strobe/read line at that edge decides which of two multiplexed handshakes follows.

Every bus input is assumed to be already synchronous to `clk`. A transfer is performed once, at the first clock edge that sees the strobe active. The acknowledge then stays high until the host releases the strobe or chip select. The memories live outside the block. The port issues a one-cycle request with stream, channel, direction and write data, and takes the read word back in the same cycle.

Top module: `hbi_host_port`

## Requirements
- R1: With `mode_sel_i` low, a transfer is active while `cs_n_i` and `ds_rd_n_i` are both low. `rw_wr_n_i` high means read and low means write. The address comes from `addr_i`, and write data is `{dhi_i, ad_i}`.
- R2: With `mode_sel_i` high, a rising edge on `as_ale_i` latches `ad_i` as the address. If `ds_rd_n_i` is low at that edge, mode A is selected; if it is high, mode B is selected. `bus_mode_o` reads 0 for non-multiplexed operation, 1 for mode A and 2 for mode B.
- R3: In mode A, a transfer is active while `cs_n_i` is low and `ds_rd_n_i` is high. `rw_wr_n_i` gives the direction (1 means read). With `ds_rd_n_i` low, no transfer takes place even when chip select is low.
- R4: In mode B, with `cs_n_i` low, `ds_rd_n_i` low is a read strobe and `rw_wr_n_i` low is a write strobe.
- R5: Addresses with bit 7 clear select registers: 0x00 mode, 0x01 control, 0x02 frame alignment, 0x03 frame offset. The mode, control and offset registers read back what was written, and they appear on `cfg_mode_o`, `cfg_ctrl_o` and `cfg_offset_o`.
- R6: Addresses of the form 1_00_ccccc reach channel ccccc of a memory. Control bits [3:0] give the stream on `mem_stream_o`. Control bit 4 selects the memory: 0 is the connection memory and 1 is the data memory. A read returns `mem_rdata_i`.
- R7: The frame alignment register returns `falign_i`. Writes to it, and writes to the data memory, are acknowledged but change nothing and issue no memory write.
- R8: Reads of unmapped addresses (0x04–0x7F, 0xA0–0xFF) return zero. Writes to them are acknowledged and have no effect.
- R9: `xfer_ack_o` rises after the first clock edge that samples an active strobe. It stays high while the strobe is held and falls after the edge that samples the release. Each strobe performs exactly one access.
- R10: After a synchronous reset (`rst_n` low), all stored registers are zero, and acknowledge and output enable are low.
- R11: `data_oe_o` is high only while a read is acknowledged. During that time `{dhi_o, ad_o}` carry the read word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel_i | input | 1 | Strap: 0 non-multiplexed, 1 multiplexed |
| cs_n_i | input | 1 | Chip select, active low |
| ds_rd_n_i | input | 1 | Data strobe / read line |
| rw_wr_n_i | input | 1 | Direction / write line |
| as_ale_i | input | 1 | Address strobe / latch enable |
| addr_i | input | 8 | Non-multiplexed address |
| ad_i | input | 8 | Low data byte, also address in multiplexed modes |
| dhi_i | input | 8 | High data byte in |
| ad_o | output | 8 | Low read byte |
| dhi_o | output | 8 | High read byte |
| data_oe_o | output | 1 | Read data drive enable |
| xfer_ack_o | output | 1 | Transfer acknowledge |
| bus_mode_o | output | 2 | Active bus mode (0 direct, 1 mode A, 2 mode B) |
| falign_i | input | 16 | Frame alignment value, read-only |
| cfg_mode_o | output | 16 | Mode register contents |
| cfg_ctrl_o | output | 16 | Control register contents |
| cfg_offset_o | output | 16 | Frame offset register contents |
| mem_req_o | output | 1 | One-cycle memory access request |
| mem_we_o | output | 1 | Memory write when high |
| mem_data_sel_o | output | 1 | 1 data memory, 0 connection memory |
| mem_stream_o | output | 4 | Stream index |
| mem_chan_o | output | 5 | Channel index |
| mem_wdata_o | output | 16 | Memory write word |
| mem_rdata_i | input | 16 | Memory read word, same cycle |

## Verification
On every cycle the assertions check the following. The acknowledge never appears without chip select on the previous edge, and it drops once chip select goes high. No strobe yields two accesses. A latched bus mode changes only on a latch edge. Read-only and unmapped writes leave the stored registers alone. No memory write ever targets the data memory. Unmapped reads capture zero. Only the bench scenarios can show the parts that need a reference model. These are that each of the three handshakes moves the right word to the right register or channel, that mode A ignores a low strobe, that the stream and memory chosen through the control register steer the window, and that reset clears registers already written.

// File: rtl/hbi_pkg.sv
// Shared types for the host bus port: bus mode codes, decode targets and
// register indices. Assumes 4 registers in the low half of the address map.
package hbi_pkg;

    typedef enum logic [1:0] {
        BUS_DIRECT = 2'd0,
        BUS_MUX_A  = 2'd1,
        BUS_MUX_B  = 2'd2
    } bus_mode_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_REG  = 2'd1,
        TGT_WIN  = 2'd2
    } tgt_e;

    localparam int REG_IDX_W = 2;
    localparam logic [REG_IDX_W-1:0] REG_MODE  = 2'd0;
    localparam logic [REG_IDX_W-1:0] REG_CTRL  = 2'd1;
    localparam logic [REG_IDX_W-1:0] REG_ALIGN = 2'd2;
    localparam logic [REG_IDX_W-1:0] REG_OFFS  = 2'd3;

endpackage

// File: rtl/hbi_addr_latch.sv
// Captures the multiplexed address on a rising latch strobe and records which
// multiplexed handshake the host uses. Assumes inputs are synchronous to clk.
module hbi_addr_latch
    import hbi_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              as_ale,
    input  logic              ds_rd_n,
    input  logic [ADDR_W-1:0] ad_in,
    output logic [ADDR_W-1:0] mux_addr,
    output bus_mode_e         bus_mode
);

    logic ale_q;
    logic mode_b_q;
    logic ale_rise;

    assign ale_rise = as_ale && !ale_q;

    // Track the previous latch strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ale_q <= 1'b0;
        else        ale_q <= as_ale;
    end

    // Latch address and handshake choice on a latch edge in multiplexed mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mux_addr <= '0;
            mode_b_q <= 1'b0;
        end else if (ale_rise && mode_sel) begin
            mux_addr <= ad_in;
            mode_b_q <= ds_rd_n;
        end
    end

    // Report the handshake in force; the strap overrides the latched choice.
    always_comb begin
        if (!mode_sel)     bus_mode = BUS_DIRECT;
        else if (mode_b_q) bus_mode = BUS_MUX_B;
        else               bus_mode = BUS_MUX_A;
    end

    // R2: the latched handshake only moves on a latch edge.
    p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ale_rise |=> $stable(mode_b_q))
        else $error("handshake mode changed without a latch edge");

endmodule

// File: rtl/hbi_strobe.sv
// Turns the bus control lines into a transfer strobe and direction for the
// active handshake, emits a single access pulse and holds the acknowledge.
module hbi_strobe
    import hbi_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  bus_mode_e bus_mode,
    input  logic      cs_n,
    input  logic      ds_rd_n,
    input  logic      rw_wr_n,
    output logic      access,
    output logic      is_write,
    output logic      ack,
    output logic      read_phase
);

    logic strobe;
    logic ack_q;
    logic wr_q;

    // Decode the strobe condition for each handshake.
    always_comb begin
        strobe   = 1'b0;
        is_write = !rw_wr_n;
        case (bus_mode)
            BUS_DIRECT: strobe = !cs_n && !ds_rd_n;
            BUS_MUX_A:  strobe = !cs_n && ds_rd_n;
            BUS_MUX_B:  strobe = !cs_n && (!ds_rd_n || !rw_wr_n);
            default:    strobe = 1'b0;
        endcase
    end

    assign access     = strobe && !ack_q;
    assign ack        = ack_q;
    assign read_phase = ack_q && !wr_q;

    // Acknowledge follows the sampled strobe; direction held for the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            wr_q  <= 1'b0;
        end else begin
            ack_q <= strobe;
            if (access) wr_q <= is_write;
        end
    end

    // R9: acknowledge needs chip select on the edge before.
    p_ack_needs_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> $past(!cs_n))
        else $error("acknowledge without chip select");

    // R9: released chip select drops the acknowledge.
    p_ack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !ack_q)
        else $error("acknowledge held after release");

    // R9: one access per strobe.
    p_single_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> !access)
        else $error("two accesses from one strobe");

endmodule

// File: rtl/hbi_decode.sv
// Splits an address into register space, memory window or unmapped space.
// Assumes the top address bit picks registers (0) or the window (1).
module hbi_decode
    import hbi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CHAN_W = 5
) (
    input  logic [ADDR_W-1:0]    addr,
    output tgt_e                 tgt,
    output logic [REG_IDX_W-1:0] reg_idx,
    output logic [CHAN_W-1:0]    chan
);

    localparam int HI = ADDR_W - 1;

    // Classify the address and extract register and channel indices.
    always_comb begin
        reg_idx = addr[REG_IDX_W-1:0];
        chan    = addr[CHAN_W-1:0];
        if (!addr[HI]) begin
            tgt = (addr[HI-1:REG_IDX_W] == '0) ? TGT_REG : TGT_NONE;
        end else begin
            tgt = (addr[HI-1:CHAN_W] == '0) ? TGT_WIN : TGT_NONE;
        end
    end

endmodule

// File: rtl/hbi_regs.sv
// Register storage, memory request generation and read-data capture.
// Assumes mem_rdata is valid in the same cycle as the request.
module hbi_regs
    import hbi_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CHAN_W = 5,
    parameter int STRM_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 access,
    input  logic                 is_write,
    input  tgt_e                 tgt,
    input  logic [REG_IDX_W-1:0] reg_idx,
    input  logic [CHAN_W-1:0]    chan,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [DATA_W-1:0]    falign,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic [DATA_W-1:0]    rdata_q,
    output logic [DATA_W-1:0]    mode_q,
    output logic [DATA_W-1:0]    ctrl_q,
    output logic [DATA_W-1:0]    offs_q,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic                 mem_data_sel,
    output logic [STRM_W-1:0]    mem_stream,
    output logic [CHAN_W-1:0]    mem_chan,
    output logic [DATA_W-1:0]    mem_wdata
);

    localparam int MSEL_BIT = STRM_W;

    logic            reg_wr;
    logic [DATA_W-1:0] rd_mux;

    assign mem_data_sel = ctrl_q[MSEL_BIT];
    assign mem_stream   = ctrl_q[STRM_W-1:0];
    assign mem_chan     = chan;
    assign mem_wdata    = wdata;
    assign mem_we       = is_write;
    assign mem_req      = access && (tgt == TGT_WIN) && !(is_write && mem_data_sel);
    assign reg_wr       = access && is_write && (tgt == TGT_REG);

    // Update the writable registers; the alignment slot has no storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            ctrl_q <= '0;
            offs_q <= '0;
        end else if (reg_wr) begin
            case (reg_idx)
                REG_MODE: mode_q <= wdata;
                REG_CTRL: ctrl_q <= wdata;
                REG_OFFS: offs_q <= wdata;
                default:  ;
            endcase
        end
    end

    // Select the word a read returns.
    always_comb begin
        rd_mux = '0;
        case (tgt)
            TGT_REG: begin
                case (reg_idx)
                    REG_MODE:  rd_mux = mode_q;
                    REG_CTRL:  rd_mux = ctrl_q;
                    REG_ALIGN: rd_mux = falign;
                    default:   rd_mux = offs_q;
                endcase
            end
            TGT_WIN: rd_mux = mem_rdata;
            default: rd_mux = '0;
        endcase
    end

    // Hold the read word for the length of the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rdata_q <= '0;
        else if (access && !is_write) rdata_q <= rd_mux;
    end

    // R7 and R8: writes outside the writable registers change no stored register.
    p_ro_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (access && is_write && (tgt != TGT_REG || reg_idx == REG_ALIGN))
        |=> ($stable(mode_q) && $stable(ctrl_q) && $stable(offs_q)))
        else $error("read-only or unmapped write changed a register");

    // R8: unmapped reads capture zero.
    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !is_write && tgt == TGT_NONE) |=> (rdata_q == '0))
        else $error("unmapped read returned nonzero");

endmodule

// File: rtl/hbi_host_port.sv
// Top of the host bus port: joins the address latch, strobe handling, decode
// and register file. Assumes all bus inputs are synchronous to clk.
module hbi_host_port
    import hbi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int CHAN_W = 5,
    parameter int STRM_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel_i,
    input  logic              cs_n_i,
    input  logic              ds_rd_n_i,
    input  logic              rw_wr_n_i,
    input  logic              as_ale_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] ad_i,
    input  logic [DATA_W-ADDR_W-1:0] dhi_i,
    output logic [ADDR_W-1:0] ad_o,
    output logic [DATA_W-ADDR_W-1:0] dhi_o,
    output logic              data_oe_o,
    output logic              xfer_ack_o,
    output logic [1:0]        bus_mode_o,
    input  logic [DATA_W-1:0] falign_i,
    output logic [DATA_W-1:0] cfg_mode_o,
    output logic [DATA_W-1:0] cfg_ctrl_o,
    output logic [DATA_W-1:0] cfg_offset_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic              mem_data_sel_o,
    output logic [STRM_W-1:0] mem_stream_o,
    output logic [CHAN_W-1:0] mem_chan_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i
);

    bus_mode_e            bus_mode;
    tgt_e                 tgt;
    logic [ADDR_W-1:0]    mux_addr;
    logic [ADDR_W-1:0]    cur_addr;
    logic [REG_IDX_W-1:0] reg_idx;
    logic [CHAN_W-1:0]    chan;
    logic                 access;
    logic                 is_write;
    logic [DATA_W-1:0]    rdata_q;

    assign cur_addr   = (bus_mode == BUS_DIRECT) ? addr_i : mux_addr;
    assign bus_mode_o = bus_mode;
    assign ad_o       = rdata_q[ADDR_W-1:0];
    assign dhi_o      = rdata_q[DATA_W-1:ADDR_W];

    hbi_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel_i),
        .as_ale   (as_ale_i),
        .ds_rd_n  (ds_rd_n_i),
        .ad_in    (ad_i),
        .mux_addr (mux_addr),
        .bus_mode (bus_mode)
    );

    hbi_strobe u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_mode   (bus_mode),
        .cs_n       (cs_n_i),
        .ds_rd_n    (ds_rd_n_i),
        .rw_wr_n    (rw_wr_n_i),
        .access     (access),
        .is_write   (is_write),
        .ack        (xfer_ack_o),
        .read_phase (data_oe_o)
    );

    hbi_decode #(.ADDR_W(ADDR_W), .CHAN_W(CHAN_W)) u_decode (
        .addr    (cur_addr),
        .tgt     (tgt),
        .reg_idx (reg_idx),
        .chan    (chan)
    );

    hbi_regs #(.DATA_W(DATA_W), .CHAN_W(CHAN_W), .STRM_W(STRM_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .access       (access),
        .is_write     (is_write),
        .tgt          (tgt),
        .reg_idx      (reg_idx),
        .chan         (chan),
        .wdata        ({dhi_i, ad_i}),
        .falign       (falign_i),
        .mem_rdata    (mem_rdata_i),
        .rdata_q      (rdata_q),
        .mode_q       (cfg_mode_o),
        .ctrl_q       (cfg_ctrl_o),
        .offs_q       (cfg_offset_o),
        .mem_req      (mem_req_o),
        .mem_we       (mem_we_o),
        .mem_data_sel (mem_data_sel_o),
        .mem_stream   (mem_stream_o),
        .mem_chan     (mem_chan_o),
        .mem_wdata    (mem_wdata_o)
    );

    // R11: read data is driven only inside an acknowledge.
    p_oe_in_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> xfer_ack_o)
        else $error("read drive outside acknowledge");

    // R7: no memory write ever reaches the data memory.
    p_no_dmem_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> !mem_data_sel_o)
        else $error("write issued to data memory");

endmodule

// File: tb/hbi_host_port_bench.sv
// Bench for the host bus port: a vector table walked by one loop, then
// directed reset and corner-case tests. Inputs change on falling edges.
module hbi_host_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_sel_i = 1'b0;
    logic        cs_n_i = 1'b1;
    logic        ds_rd_n_i = 1'b1;
    logic        rw_wr_n_i = 1'b1;
    logic        as_ale_i = 1'b0;
    logic [7:0]  addr_i = '0;
    logic [7:0]  ad_i = '0;
    logic [7:0]  dhi_i = '0;
    logic [7:0]  ad_o, dhi_o;
    logic        data_oe_o, xfer_ack_o;
    logic [1:0]  bus_mode_o;
    logic [15:0] falign_i = 16'h0C3A;
    logic [15:0] cfg_mode_o, cfg_ctrl_o, cfg_offset_o;
    logic        mem_req_o, mem_we_o, mem_data_sel_o;
    logic [3:0]  mem_stream_o;
    logic [4:0]  mem_chan_o;
    logic [15:0] mem_wdata_o;
    logic [15:0] mem_rdata_i;

    int tests = 0;
    int fails = 0;
    int dmem_writes = 0;
    int cycles = 0;

    logic [15:0] conn_mem [512];

    always #5 clk = ~clk;

    hbi_host_port u_hbi_host_port (
        .clk(clk), .rst_n(rst_n), .mode_sel_i(mode_sel_i), .cs_n_i(cs_n_i),
        .ds_rd_n_i(ds_rd_n_i), .rw_wr_n_i(rw_wr_n_i), .as_ale_i(as_ale_i),
        .addr_i(addr_i), .ad_i(ad_i), .dhi_i(dhi_i), .ad_o(ad_o), .dhi_o(dhi_o),
        .data_oe_o(data_oe_o), .xfer_ack_o(xfer_ack_o), .bus_mode_o(bus_mode_o),
        .falign_i(falign_i), .cfg_mode_o(cfg_mode_o), .cfg_ctrl_o(cfg_ctrl_o),
        .cfg_offset_o(cfg_offset_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_data_sel_o(mem_data_sel_o), .mem_stream_o(mem_stream_o),
        .mem_chan_o(mem_chan_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
    );

    // Memory model: connection memory is stored, data memory is a pattern.
    always_comb begin
        if (mem_data_sel_o) mem_rdata_i = 16'hD000 | {7'd0, mem_stream_o, mem_chan_o};
        else                mem_rdata_i = conn_mem[{mem_stream_o, mem_chan_o}];
    end

    always @(posedge clk) begin
        if (mem_req_o && mem_we_o) begin
            if (mem_data_sel_o) dmem_writes++;
            else conn_mem[{mem_stream_o, mem_chan_o}] <= mem_wdata_o;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus transfer: kind 0 direct, 1 mux mode A, 2 mux mode B.
    task automatic bus_cycle(input int kind, input bit wr, input logic [7:0] a,
                             input logic [15:0] wd, output logic [15:0] rd);
        @(negedge clk);
        mode_sel_i = (kind != 0);
        cs_n_i = 1'b1;
        if (kind == 0) begin
            ds_rd_n_i = 1'b1;
            addr_i = a; ad_i = wd[7:0]; dhi_i = wd[15:8]; rw_wr_n_i = !wr;
            @(negedge clk);
            chk("R1 mode", {14'd0, bus_mode_o}, 16'd0);
        end else begin
            ds_rd_n_i = (kind == 2);
            rw_wr_n_i = 1'b1;
            ad_i = a; as_ale_i = 1'b0;
            @(negedge clk); as_ale_i = 1'b1;
            @(negedge clk); as_ale_i = 1'b0;
            chk("R2 mode", {14'd0, bus_mode_o}, 16'(kind));
            ad_i = wd[7:0]; dhi_i = wd[15:8];
            if (kind == 1) rw_wr_n_i = !wr;
        end
        cs_n_i = 1'b0;
        case (kind)
            0: ds_rd_n_i = 1'b0;
            1: ds_rd_n_i = 1'b1;
            default: if (wr) rw_wr_n_i = 1'b0; else ds_rd_n_i = 1'b0;
        endcase
        @(negedge clk);
        chk("R9 ack rise", {15'd0, xfer_ack_o}, 16'd1);
        chk("R11 oe", {15'd0, data_oe_o}, {15'd0, !wr});
        rd = {dhi_o, ad_o};
        @(negedge clk);
        chk("R9 ack hold", {15'd0, xfer_ack_o}, 16'd1);
        cs_n_i = 1'b1;
        ds_rd_n_i = (kind != 1) ? 1'b1 : 1'b0;
        rw_wr_n_i = 1'b1;
        @(negedge clk);
        chk("R9 ack fall", {15'd0, xfer_ack_o}, 16'd0);
    endtask

    // Vector: {kind[1:0], write, address[7:0], write data or expected read}.
    localparam int NV = 19;
    localparam logic [26:0] VEC [NV] = '{
        {2'd0, 1'b1, 8'h00, 16'hA5A5},   // R1 R5 write mode reg
        {2'd0, 1'b0, 8'h00, 16'hA5A5},   // R1 R5 read back
        {2'd1, 1'b1, 8'h01, 16'h0003},   // R3 R6 stream 3, connection memory
        {2'd2, 1'b0, 8'h01, 16'h0003},   // R4 R5 read control
        {2'd0, 1'b1, 8'h85, 16'h1234},   // R6 conn s3 c5
        {2'd1, 1'b0, 8'h85, 16'h1234},   // R3 R6 read it via mode A
        {2'd2, 1'b1, 8'h03, 16'hBEEF},   // R4 R5 offset write
        {2'd0, 1'b0, 8'h03, 16'hBEEF},   // R5 offset read
        {2'd2, 1'b1, 8'h02, 16'hFFFF},   // R7 alignment write ignored
        {2'd1, 1'b0, 8'h02, 16'h0C3A},   // R7 alignment returns input
        {2'd0, 1'b1, 8'h01, 16'h0017},   // R6 data memory, stream 7
        {2'd2, 1'b1, 8'h9F, 16'h5555},   // R7 data memory write ignored
        {2'd0, 1'b0, 8'h9F, 16'hD0FF},   // R6 data memory s7 c31
        {2'd1, 1'b0, 8'h04, 16'h0000},   // R8 unmapped register space
        {2'd0, 1'b1, 8'hA0, 16'h7777},   // R8 unmapped write
        {2'd2, 1'b0, 8'hA0, 16'h0000},   // R8 unmapped window space
        {2'd0, 1'b0, 8'h7F, 16'h0000},   // R8 top of register space
        {2'd0, 1'b1, 8'h01, 16'h0007},   // R6 back to connection memory
        {2'd2, 1'b0, 8'h9F, 16'h0000}    // R7 conn s7 c31 untouched
    };

    // Watchdog: an overrun counts as a failed check.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000) begin
                fails++;
                tests++;
                $display("FAIL watchdog actual=%0d expected=<50000 cycles", cycles);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [15:0] rd;
        for (int i = 0; i < 512; i++) conn_mem[i] = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 ack", {15'd0, xfer_ack_o}, 16'd0);
        chk("R10 oe", {15'd0, data_oe_o}, 16'd0);
        chk("R10 ctrl", cfg_ctrl_o, 16'd0);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            bus_cycle(int'(VEC[i][26:25]), VEC[i][24], VEC[i][23:16], VEC[i][15:0], rd);
            if (!VEC[i][24]) chk($sformatf("R5-R8 vector %0d", i), rd, VEC[i][15:0]);
        end

        // R5 register contents visible at outputs
        chk("R5 cfg mode", cfg_mode_o, 16'hA5A5);
        chk("R5 cfg offset", cfg_offset_o, 16'hBEEF);
        chk("R6 stream out", {12'd0, mem_stream_o}, 16'd7);
        // R7 no write reached the data memory
        chk("R7 dmem writes", 16'(dmem_writes), 16'd0);

        // R3: mode A ignores a low strobe even with chip select
        @(negedge clk);
        mode_sel_i = 1'b1; ds_rd_n_i = 1'b0; ad_i = 8'h00; as_ale_i = 1'b1;
        @(negedge clk); as_ale_i = 1'b0; cs_n_i = 1'b0;
        repeat (2) @(negedge clk);
        chk("R3 no strobe", {15'd0, xfer_ack_o}, 16'd0);
        cs_n_i = 1'b1;
        @(negedge clk);

        // R10: reset clears registers already written
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 mode cleared", cfg_mode_o, 16'd0);
        chk("R10 offset cleared", cfg_offset_o, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule